// File: doc/BRIEF.md
# Machine Security Configuration Register

This block holds the machine-mode security configuration control word for a core with physical memory protection. A control-register access arrives with a valid strobe, an operation code and a write-data operand; the block returns the value it held before the access in the same cycle, and the new value appears after the next rising clock edge.

Only three control bits exist: a lockdown bit, a whitelist-policy bit and a rule-lock bypass bit. The lockdown and whitelist-policy bits are sticky: once they are 1, only reset clears them. The bypass bit can be raised only while no protection entry is locked, which a single input reports as the OR of all entry lock bits. The three bits go straight out to the protection checker. Address decode and privilege checks happen outside this block.

Top module: `sec_cfg_reg`

## Requirements
- R1: Operation codes on op_i: 0 = read (no change), 1 = write (unlocked bits take wdata), 2 = set (unlocked bits OR wdata), 3 = clear (unlocked bits AND NOT wdata). An access takes effect on the rising edge where valid_i is 1. With valid_i at 0, nothing changes.
- R2: rdata_o always shows the value held before the access. It is combinational with the held value, so it is valid in the same cycle.
- R3: Bits 31..3 of the held value and of rdata_o are always zero, whatever the write data.
- R4: Bit 1 (whitelist policy) is cleared by no write and by no clear once it is 1.
- R5: Bit 0 (lockdown) is cleared by no write and by no clear once it is 1.
- R6: While bit 2 (bypass) is 0 and any_locked_i is 1, no access sets bit 2.
- R7: When bit 2 is 1, or any_locked_i is 0, bit 2 follows the operation freely.
- R8: After reset the held value is zero.
- R9: mml_o, mmwp_o and rlb_o equal bits 0, 1 and 2 of the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Access strobe |
| op_i | input | 2 | Operation code |
| wdata_i | input | 32 | Write operand |
| any_locked_i | input | 1 | OR of all protection entry lock bits |
| rdata_o | output | 32 | Value before the access |
| mml_o | output | 1 | Lockdown bit |
| mmwp_o | output | 1 | Whitelist-policy bit |
| rlb_o | output | 1 | Rule-lock bypass bit |

## Verification
The bench sweeps every operation code, every 3-bit starting value, every low 3-bit operand with random upper bits, and both levels of the locked input. It computes the expected next value arithmetically from the requirements. Starting values with the sticky bits already set separate the sticky masking from ordinary clears. Patterns with bypass at 0 and at 1 under a locked input separate the bypass gate from a plain lock. Accesses with valid low, and operand words with upper bits set, show that idle cycles and reserved bits have no effect.

// File: rtl/sec_cfg_pkg.sv
package sec_cfg_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned NBITS = 3;
  localparam int unsigned MML_BIT = 0;
  localparam int unsigned MMWP_BIT = 1;
  localparam int unsigned RLB_BIT = 2;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;
endpackage

// File: rtl/sec_cfg_lock.sv
module sec_cfg_lock
  import sec_cfg_pkg::*;
(
  input  logic [NBITS-1:0] cur_i,
  input  logic             any_locked_i,
  output logic [NBITS-1:0] lock_mask_o
);
  always_comb begin
    lock_mask_o = '0;
    lock_mask_o[MML_BIT]  = cur_i[MML_BIT];
    lock_mask_o[MMWP_BIT] = cur_i[MMWP_BIT];
    // bypass frozen at 0 while any entry is locked
    lock_mask_o[RLB_BIT]  = any_locked_i & ~cur_i[RLB_BIT];
  end
endmodule

// File: rtl/sec_cfg_update.sv
module sec_cfg_update
  import sec_cfg_pkg::*;
(
  input  csr_op_e          op_i,
  input  logic [NBITS-1:0] cur_i,
  input  logic [NBITS-1:0] wdata_i,
  input  logic [NBITS-1:0] lock_mask_i,
  output logic [NBITS-1:0] next_o
);
  logic [NBITS-1:0] raw;
  always_comb begin
    unique case (op_i)
      OP_WRITE: raw = wdata_i;
      OP_SET:   raw = cur_i | wdata_i;
      OP_CLEAR: raw = cur_i & ~wdata_i;
      default:  raw = cur_i;
    endcase
    next_o = (cur_i & lock_mask_i) | (raw & ~lock_mask_i);
  end
endmodule

// File: rtl/sec_cfg_reg.sv
module sec_cfg_reg
  import sec_cfg_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [1:0]      op_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            any_locked_i,
  output logic [XLEN-1:0] rdata_o,
  output logic            mml_o,
  output logic            mmwp_o,
  output logic            rlb_o
);
  logic [NBITS-1:0] cfg_q, cfg_d, lock_mask;

  sec_cfg_lock u_lock (
    .cur_i        (cfg_q),
    .any_locked_i (any_locked_i),
    .lock_mask_o  (lock_mask)
  );

  sec_cfg_update u_upd (
    .op_i        (csr_op_e'(op_i)),
    .cur_i       (cfg_q),
    .wdata_i     (wdata_i[NBITS-1:0]),
    .lock_mask_i (lock_mask),
    .next_o      (cfg_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_q <= '0;
    else if (valid_i) cfg_q <= cfg_d;
  end

  assign rdata_o = {{(XLEN-NBITS){1'b0}}, cfg_q};
  assign mml_o   = cfg_q[MML_BIT];
  assign mmwp_o  = cfg_q[MMWP_BIT];
  assign rlb_o   = cfg_q[RLB_BIT];

  // R3
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[XLEN-1:NBITS] == '0);
  // R4
  mmwp_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mmwp_o |=> mmwp_o);
  // R5
  mml_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mml_o |=> mml_o);
  // R6
  rlb_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rlb_o && any_locked_i) |=> !rlb_o);
  // R1
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(rdata_o));
  // R1
  read_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd0) |=> $stable(rdata_o));
endmodule

// File: tb/sec_cfg_reg_bench.sv
module sec_cfg_reg_bench;
  logic clk = 0, rst_ni = 0, valid = 0, locked = 0;
  logic [1:0] op = 0;
  logic [31:0] wdata = 0, rdata;
  logic mml, mmwp, rlb;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sec_cfg_reg u_sec_cfg_reg (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .op_i(op), .wdata_i(wdata),
    .any_locked_i(locked), .rdata_o(rdata), .mml_o(mml), .mmwp_o(mmwp), .rlb_o(rlb));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] model(logic [2:0] c, int o, logic [2:0] w, logic lk);
    logic [2:0] r, m;
    case (o)
      1: r = w;
      2: r = c | w;
      3: r = c & ~w;
      default: r = c;
    endcase
    m = {lk & ~c[2], c[1], c[0]};
    return (c & m) | (r & ~m);
  endfunction

  // Reach state s: reset, then write with no lock (all bits free).
  task automatic load(logic [2:0] s);
    @(negedge clk); rst_ni = 0; valid = 0;
    @(negedge clk); rst_ni = 1;
    valid = 1; op = 1; wdata = {29'h0, s}; locked = 0;
    @(negedge clk); valid = 0;
  endtask

  initial begin
    #1;
    repeat (2) @(negedge clk);
    chk("R8", rdata, 0);
    rst_ni = 1;
    @(negedge clk);
    chk("R8", {29'h0, rlb, mmwp, mml}, 0);
    for (int s = 0; s < 8; s++)
      for (int o = 0; o < 4; o++)
        for (int w = 0; w < 8; w++)
          for (int lk = 0; lk < 2; lk++) begin
            logic [2:0] exp;
            load(s[2:0]);
            chk("R2", rdata, {29'h0, s[2:0]});
            valid = 1; op = o[1:0]; locked = lk[0];
            wdata = {$urandom() & 32'hFFFF_FFF8} | w;
            #1 chk("R2", rdata, {29'h0, s[2:0]});
            exp = model(s[2:0], o, w[2:0], lk[0]);
            @(negedge clk); valid = 0;
            if (s[1] || s[0]) chk("R4/R5", rdata, {29'h0, exp});
            else if (lk[0] && !s[2]) chk("R6", rdata, {29'h0, exp});
            else chk("R1/R7", rdata, {29'h0, exp});
            chk("R3", rdata & 32'hFFFF_FFF8, 0);
            chk("R9", {29'h0, rlb, mmwp, mml}, {29'h0, exp});
            // idle cycle with hostile inputs: no change
            op = 1; wdata = 0; locked = 0;
            @(negedge clk);
            chk("R1", rdata, {29'h0, exp});
          end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule